// File: doc/BRIEF.md
# Slave-Mode Timer Counter

This block is a counter of parameterised width (16 bits by default) whose advance, direction and restart are governed by a slave controller. A 3-bit mode input chooses one of eight ways to move the counter. These are free running on the clock, three quadrature-decoder variants, restart on a trigger, counting while a trigger level is high, starting on a trigger, and counting trigger edges. A 3-bit source select routes one of eight lines to the internal trigger. The eight lines are four on-chip trigger lines, an edge indication from input channel A, channel A itself, channel B and an external trigger that has already been filtered.

The counter wraps between zero and a programmable reload value. Each wrap or restart raises a one-cycle update pulse. A synchronisation option holds every trigger effect back by one clock. In every case a one-cycle trigger output marks the cycle in which the effect becomes visible, so timers chained on that output stay aligned with this one. All inputs are synchronous to the clock, and edges are found by comparing each input with its value one clock earlier. The count, the direction and the two pulses are all registered, so each reaction appears on the first clock edge after the stimulus. With the delay option, it appears on the second.

Top module: `slave_timer`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (up), and the update and trigger outputs are low.
- R2: Mode code 0 adds one on every clock while `cntEn` is high and holds the count while it is low.
- R3: A step up from a count at or above `reloadVal` gives 0. A step down from 0 gives `reloadVal`. Either wrap raises `updPulse` in the cycle that shows the wrapped count.
- R4: Mode code 1, with `cntEn` high, steps once for each change of `chanA`. After the change, equal levels on `chanA` and `chanB` mean up and unequal levels mean down. A change on `chanB` alone does nothing. `dirDown` shows the last step's direction (1 = down).
- R5: Mode code 2 is mode 1 with the roles swapped. A change of `chanB` steps up when the two levels are then equal and down otherwise. A change on `chanA` alone does nothing.
- R6: Mode code 3 steps on a change of either channel. A change of `chanA` steps up when the levels are then equal. A change of `chanB` steps up when they then differ. A cycle in which both channels change gives no step.
- R7: Mode code 4 counts up as in R2. A rising trigger sets the count to 0, sets the direction to up and raises `updPulse`. This holds even when a step is due in the same cycle.
- R8: Mode code 5 adds one on each clock in which both the trigger and `cntEn` are high.
- R9: Mode code 6 leaves the count untouched until a rising trigger. From that edge on it adds one every clock, whatever `cntEn` is, until the mode code changes. The count is not cleared when it starts.
- R10: Mode code 7, with `cntEn` high, adds one per rising edge of the trigger and holds otherwise.
- R11: The trigger source is chosen by `trigSel`. Codes 0 to 3 take `intTrig[0]` to `intTrig[3]`, code 4 takes `chanAEdge`, 5 takes `chanA`, 6 takes `chanB` and 7 takes `extTrig`. Unselected lines have no effect.
- R12: With `syncDelay` high, a trigger takes effect one clock later than without it. `trgOut` is high for one cycle, the cycle in which the count first reflects the trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Counter enable |
| modeSel | input | 3 | Slave mode code (0 to 7) |
| trigSel | input | 3 | Trigger source code (0 to 7) |
| syncDelay | input | 1 | Hold trigger effects back by one clock |
| reloadVal | input | CNT_W | Top value of the count range |
| chanA | input | 1 | Filtered input channel A |
| chanB | input | 1 | Filtered input channel B |
| chanAEdge | input | 1 | Edge indication derived from channel A |
| intTrig | input | 4 | On-chip trigger lines |
| extTrig | input | 1 | Filtered external trigger |
| count | output | CNT_W | Counter value |
| dirDown | output | 1 | Direction of the last step, 1 = down |
| updPulse | output | 1 | One-cycle pulse on wrap or restart |
| trgOut | output | 1 | One-cycle pulse when a trigger takes effect |

## Verification
In restart mode, the trigger-driven clear and the enable-driven step can fall in the same cycle. The bench lets the counter run with `cntEn` high and then raises the selected trigger line on a cycle in which a step is also due. It expects a count of 0, not 1, together with exactly one update pulse and a trigger-output pulse. On the following cycle it expects an ordinary step to 1 with the update pulse low. In mode 3 the bench also toggles both channels in one cycle and expects neither a step nor a change of direction.

// File: rtl/slave_timer_pkg.sv
package slave_timer_pkg;

  typedef enum logic [2:0] {
    MODE_FREE   = 3'd0,
    MODE_ENC_A  = 3'd1,
    MODE_ENC_B  = 3'd2,
    MODE_ENC_AB = 3'd3,
    MODE_RESTART= 3'd4,
    MODE_GATED  = 3'd5,
    MODE_START  = 3'd6,
    MODE_EDGECK = 3'd7
  } slvMode_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic clear;
    logic evt;
  } tmrStrobe_t;

endpackage

// File: rtl/slave_timer_ctrl.sv
module slave_timer_ctrl
  import slave_timer_pkg::*;
#(
  parameter int N_INT_TRIG = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cntEn,
  input  logic [2:0]            modeSel,
  input  logic [2:0]            trigSel,
  input  logic                  syncDelay,
  input  logic                  chanA,
  input  logic                  chanB,
  input  logic                  chanAEdge,
  input  logic [N_INT_TRIG-1:0] intTrig,
  input  logic                  extTrig,
  output tmrStrobe_t            strb
);

  localparam int SEL_W = $clog2(N_INT_TRIG + 4);

  slvMode_e mode;
  logic     prevA, prevB;
  logic     trgi, trgiDly, effLevel, effPrev, effRise;
  logic     runFlag;
  logic     aEdge, bEdge, levelsEq;

  assign mode = slvMode_e'(modeSel);

  // trigger source mux
  always_comb begin
    trgi = 1'b0;
    if (int'(trigSel) < N_INT_TRIG) begin
      trgi = intTrig[trigSel[SEL_W-2:0]];
    end else begin
      case (trigSel)
        3'd4:    trgi = chanAEdge;
        3'd5:    trgi = chanA;
        3'd6:    trgi = chanB;
        default: trgi = extTrig;
      endcase
    end
  end

  assign effLevel = syncDelay ? trgiDly : trgi;
  assign effRise  = effLevel & ~effPrev;
  assign aEdge    = chanA ^ prevA;
  assign bEdge    = chanB ^ prevB;
  assign levelsEq = (chanA == chanB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevA   <= 1'b0;
      prevB   <= 1'b0;
      trgiDly <= 1'b0;
      effPrev <= 1'b0;
      runFlag <= 1'b0;
    end else begin
      prevA   <= chanA;
      prevB   <= chanB;
      trgiDly <= trgi;
      effPrev <= effLevel;
      runFlag <= (mode == MODE_START) && (runFlag || effRise);
    end
  end

  always_comb begin
    strb = '0;
    strb.evt = effRise;
    case (mode)
      MODE_FREE: strb.stepUp = cntEn;
      MODE_ENC_A: if (cntEn && aEdge) begin
        strb.stepUp   = levelsEq;
        strb.stepDown = !levelsEq;
      end
      MODE_ENC_B: if (cntEn && bEdge) begin
        strb.stepUp   = levelsEq;
        strb.stepDown = !levelsEq;
      end
      MODE_ENC_AB: if (cntEn && (aEdge ^ bEdge)) begin
        strb.stepUp   = aEdge ? levelsEq : !levelsEq;
        strb.stepDown = aEdge ? !levelsEq : levelsEq;
      end
      MODE_RESTART: begin
        strb.stepUp = cntEn;
        strb.clear  = effRise;
      end
      MODE_GATED:  strb.stepUp = cntEn && effLevel;
      MODE_START:  strb.stepUp = runFlag || effRise;
      MODE_EDGECK: strb.stepUp = cntEn && effRise;
      default: ;
    endcase
  end

  // R4: never up and down together
  a_r4_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.stepUp, strb.stepDown}));

  // R6: simultaneous channel changes in dual-edge mode give no step
  a_r6_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ENC_AB && aEdge && bEdge) |-> !(strb.stepUp || strb.stepDown));

  // R12: a raw rising trigger surfaces exactly one clock later when delayed
  a_r12_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (syncDelay && trgi && !trgiDly) |=> (!syncDelay || strb.evt));

endmodule

// File: rtl/slave_timer_dp.sv
module slave_timer_dp
  import slave_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic             updPulse,
  output logic             trgOut
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      dirDown  <= 1'b0;
      updPulse <= 1'b0;
      trgOut   <= 1'b0;
    end else begin
      updPulse <= 1'b0;
      trgOut   <= strb.evt;
      if (strb.clear) begin
        count    <= '0;
        dirDown  <= 1'b0;
        updPulse <= 1'b1;
      end else if (strb.stepUp) begin
        dirDown <= 1'b0;
        if (count >= reloadVal) begin
          count    <= '0;
          updPulse <= 1'b1;
        end else begin
          count <= count + ONE;
        end
      end else if (strb.stepDown) begin
        dirDown <= 1'b1;
        if (count == '0) begin
          count    <= reloadVal;
          updPulse <= 1'b1;
        end else begin
          count <= count - ONE;
        end
      end
    end
  end

  a_r3_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepUp && !strb.clear && count >= reloadVal) |=> (count == '0 && updPulse));

  a_r3_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepDown && !strb.clear && count == '0)
      |=> (count == $past(reloadVal) && updPulse && dirDown));

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> (count == '0 && updPulse && !dirDown));

endmodule

// File: rtl/slave_timer.sv
module slave_timer
  import slave_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEn,
  input  logic [2:0]       modeSel,
  input  logic [2:0]       trigSel,
  input  logic             syncDelay,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             chanA,
  input  logic             chanB,
  input  logic             chanAEdge,
  input  logic [3:0]       intTrig,
  input  logic             extTrig,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic             updPulse,
  output logic             trgOut
);

  tmrStrobe_t strb;

  slave_timer_ctrl #(.N_INT_TRIG(4)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .modeSel(modeSel),
    .trigSel(trigSel), .syncDelay(syncDelay), .chanA(chanA), .chanB(chanB),
    .chanAEdge(chanAEdge), .intTrig(intTrig), .extTrig(extTrig), .strb(strb)
  );

  slave_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reloadVal(reloadVal),
    .count(count), .dirDown(dirDown), .updPulse(updPulse), .trgOut(trgOut)
  );

endmodule

// File: tb/slave_timer_tb.sv
module slave_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cntEn;
  logic [2:0]  modeSel, trigSel;
  logic        syncDelay;
  logic [15:0] reloadVal;
  logic        chanA, chanB, chanAEdge, extTrig;
  logic [3:0]  intTrig;
  logic [15:0] count;
  logic        dirDown, updPulse, trgOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  slave_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .modeSel(modeSel),
    .trigSel(trigSel), .syncDelay(syncDelay), .reloadVal(reloadVal),
    .chanA(chanA), .chanB(chanB), .chanAEdge(chanAEdge), .intTrig(intTrig),
    .extTrig(extTrig), .count(count), .dirDown(dirDown),
    .updPulse(updPulse), .trgOut(trgOut)
  );

  // {mode[2:0], a, b, count[15:0], dirDown, updPulse}
  localparam int NV = 19;
  localparam logic [22:0] VECS [NV] = '{
    {3'd1, 1'b1, 1'b0, 16'd100, 1'b1, 1'b1},  // R4 down from 0 wraps (R3)
    {3'd1, 1'b1, 1'b1, 16'd100, 1'b1, 1'b0},  // R4 B alone ignored
    {3'd1, 1'b0, 1'b1, 16'd99,  1'b1, 1'b0},  // R4 differ -> down
    {3'd1, 1'b1, 1'b1, 16'd100, 1'b0, 1'b0},  // R4 equal -> up
    {3'd1, 1'b0, 1'b1, 16'd99,  1'b1, 1'b0},
    {3'd1, 1'b1, 1'b1, 16'd100, 1'b0, 1'b0},
    {3'd2, 1'b1, 1'b0, 16'd99,  1'b1, 1'b0},  // R5 B fall, differ
    {3'd2, 1'b0, 1'b0, 16'd99,  1'b1, 1'b0},  // R5 A alone ignored
    {3'd2, 1'b0, 1'b1, 16'd98,  1'b1, 1'b0},
    {3'd2, 1'b1, 1'b1, 16'd98,  1'b1, 1'b0},
    {3'd2, 1'b1, 1'b0, 16'd97,  1'b1, 1'b0},
    {3'd2, 1'b1, 1'b1, 16'd98,  1'b0, 1'b0},  // R5 equal -> up
    {3'd3, 1'b0, 1'b1, 16'd97,  1'b1, 1'b0},  // R6 A edge differ
    {3'd3, 1'b0, 1'b0, 16'd96,  1'b1, 1'b0},  // R6 B edge equal -> down
    {3'd3, 1'b1, 1'b0, 16'd95,  1'b1, 1'b0},
    {3'd3, 1'b1, 1'b1, 16'd94,  1'b1, 1'b0},
    {3'd3, 1'b1, 1'b0, 16'd95,  1'b0, 1'b0},  // R6 reverse
    {3'd3, 1'b0, 1'b0, 16'd96,  1'b0, 1'b0},
    {3'd3, 1'b1, 1'b1, 16'd96,  1'b0, 1'b0}   // R6 both change -> none
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setSrc(input int idx, input logic v);
    case (idx)
      0, 1, 2, 3: intTrig[idx] = v;
      4: chanAEdge = v;
      5: chanA = v;
      6: chanB = v;
      default: extTrig = v;
    endcase
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    cntEn = 1'b0; modeSel = 3'd0; trigSel = 3'd0; syncDelay = 1'b0;
    reloadVal = 16'd100; chanA = 1'b0; chanB = 1'b0; chanAEdge = 1'b0;
    intTrig = 4'd0; extTrig = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp;
    doReset();
    chk("R1 count", count, 16'd0);
    chk("R1 dir", {15'd0, dirDown}, 16'd0);
    chk("R1 upd", {15'd0, updPulse}, 16'd0);
    chk("R1 trg", {15'd0, trgOut}, 16'd0);

    // encoder table
    @(negedge clk); modeSel = 3'd1; cntEn = 1'b1;
    tick();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      modeSel = VECS[i][22:20]; chanA = VECS[i][19]; chanB = VECS[i][18];
      tick();
      chk("R4/R5/R6 count", count, VECS[i][17:2]);
      chk("R4/R5/R6 dir", {15'd0, dirDown}, {15'd0, VECS[i][1]});
      chk("R3 upd", {15'd0, updPulse}, {15'd0, VECS[i][0]});
    end

    // R2 free run and R3 up wrap
    doReset();
    @(negedge clk); reloadVal = 16'd3; cntEn = 1'b1;
    repeat (3) tick();
    chk("R2 free run", count, 16'd3);
    chk("R3 no upd before wrap", {15'd0, updPulse}, 16'd0);
    tick();
    chk("R3 up wrap", count, 16'd0);
    chk("R3 upd on wrap", {15'd0, updPulse}, 16'd1);
    @(negedge clk); cntEn = 1'b0;
    repeat (2) tick();
    chk("R2 hold", count, 16'd0);

    // R7 restart mode, clear collides with step
    doReset();
    @(negedge clk); modeSel = 3'd4; cntEn = 1'b1;
    repeat (3) tick();
    chk("R7 counts", count, 16'd3);
    @(negedge clk); intTrig[0] = 1'b1;
    tick();
    chk("R7 clear wins", count, 16'd0);
    chk("R7 upd", {15'd0, updPulse}, 16'd1);
    chk("R12 trgOut", {15'd0, trgOut}, 16'd1);
    tick();
    chk("R7 step after", count, 16'd1);
    chk("R7 single upd", {15'd0, updPulse}, 16'd0);

    // R8 gated
    doReset();
    @(negedge clk); modeSel = 3'd5; cntEn = 1'b1; trigSel = 3'd7;
    repeat (2) tick();
    chk("R8 gate low", count, 16'd0);
    @(negedge clk); extTrig = 1'b1;
    repeat (3) tick();
    chk("R8 gate high", count, 16'd3);
    @(negedge clk); extTrig = 1'b0;
    repeat (2) tick();
    chk("R8 gate closed", count, 16'd3);

    // R9 start mode
    doReset();
    @(negedge clk); cntEn = 1'b1;
    repeat (2) tick();
    @(negedge clk); cntEn = 1'b0; modeSel = 3'd6;
    repeat (2) tick();
    chk("R9 idle", count, 16'd2);
    @(negedge clk); intTrig[0] = 1'b1;
    tick();
    chk("R9 start no clear", count, 16'd3);
    @(negedge clk); intTrig[0] = 1'b0;
    repeat (2) tick();
    chk("R9 runs", count, 16'd5);
    @(negedge clk); modeSel = 3'd5;
    repeat (2) tick();
    chk("R9 stops on mode change", count, 16'd5);

    // R10 / R11 source select in edge-clock mode
    doReset();
    @(negedge clk); modeSel = 3'd7; cntEn = 1'b1;
    exp = 0;
    for (int sel = 0; sel < 8; sel++) begin
      @(negedge clk); trigSel = 3'(sel); setSrc((sel + 1) % 8, 1'b1);
      tick();
      chk("R11 other source ignored", count, 16'(exp));
      @(negedge clk); setSrc((sel + 1) % 8, 1'b0);
      tick();
      @(negedge clk); setSrc(sel, 1'b1);
      tick();
      exp++;
      chk("R10/R11 selected edge", count, 16'(exp));
      chk("R12 trgOut", {15'd0, trgOut}, 16'd1);
      tick();
      chk("R10 level does not count", count, 16'(exp));
      @(negedge clk); setSrc(sel, 1'b0);
      tick();
    end

    // R12 sync delay
    doReset();
    @(negedge clk); modeSel = 3'd7; cntEn = 1'b1; trigSel = 3'd5; syncDelay = 1'b1;
    tick();
    @(negedge clk); chanA = 1'b1;
    tick();
    chk("R12 held back", count, 16'd0);
    chk("R12 no early trgOut", {15'd0, trgOut}, 16'd0);
    tick();
    chk("R12 delayed effect", count, 16'd1);
    chk("R12 trgOut aligned", {15'd0, trgOut}, 16'd1);
    tick();
    chk("R12 trgOut one cycle", {15'd0, trgOut}, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule